// File: doc/BRIEF.md
# Serial Bit-Clock Recovery Loop

This block recovers a bit clock from an NRZ or NRZI serial stream. Each bit cell is split into 32 counts, and the block runs two clock ticks per count, so `clk` is supplied at 64 times the data rate. A phase counter counts half-counts, which lets it resolve an edge to half a count. The counter wraps once per bit cell. The nominal cell boundary sits between count 15 and count 16, which is half-count position 32. The recovered clock rises at position 0, in the middle of the cell, so a receiver that samples on that rising edge samples mid-cell.

Software controls the loop with three single-cycle strobes: start/restart search, stop, and mode write. A search hard-syncs the counter to the first data transition it sees. After that the loop either tracks or coasts. In tracking mode, a transition away from the expected boundary moves the current cell by one count, earlier or later, at most once per cell. A narrow window around the boundary applies no correction. Both data polarities are edges. The transmit and receive clock outputs are identical.

Top module: `cdr_dpll`

## Requirements
- R1: After reset the loop is stopped: `rx_clk`, `tx_clk`, `searching` and `locked` are all 0, and the mode is tracking.
- R2: While stopped, the counter holds and transitions on `rx_data` are ignored: both clocks stay 0 and `locked` stays 0.
- R3: A `cmd_search` pulse moves the loop into search (`searching`=1). The counter is held at the boundary position (32), and both clocks stay 0 until a data transition arrives.
- R4: The first transition seen in search locks the loop (`locked`=1, `searching`=0). If `rx_data` changes just after clock edge X, the first rising edge of `rx_clk` occurs at clock edge X+34. This is three cycles of input sync and edge detection plus 31 cycles to mid-cell.
- R5: With no further transitions, `rx_clk` repeats every 64 cycles, high for 32 and low for 32. `tx_clk` always equals `rx_clk`.
- R6: An edge position is defined as follows. If `rx_data` changes just after the clock edge that raised `rx_clk` plus k cycles, it lands at position (k+2) mod 64. A transition at position 31 or 32 makes no correction, so the cell lasts 64 cycles.
- R7: In tracking mode, a transition at positions 0 to 30 shortens the current cell to 62 cycles, one count less.
- R8: In tracking mode, a transition at positions 33 to 63 lengthens the current cell to 66 cycles, one count more.
- R9: At most one correction is applied per cell. Later transitions in the same cell have no effect.
- R10: `cmd_search` while locked drops `locked`, sets `searching` and forces the clocks to 0. The loop then relocks on the next transition with the R4 timing.
- R11: `cmd_mode_wr` loads `mode_sel` (0 = tracking, 1 = coast) only while the loop is stopped. It is ignored while searching or locked. In coast mode the loop still hard-syncs, but every cell lasts 64 cycles.
- R12: When `cmd_disable` and `cmd_search` are asserted in the same cycle, the stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-count tick, 64 times the data rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 1 | Asynchronous serial data |
| cmd_search | input | 1 | Start or restart search (one-cycle strobe) |
| cmd_disable | input | 1 | Stop the loop (one-cycle strobe) |
| cmd_mode_wr | input | 1 | Load `mode_sel` while stopped |
| mode_sel | input | 1 | 0 = tracking, 1 = coast |
| rx_clk | output | 1 | Recovered receive clock, rising mid-cell |
| tx_clk | output | 1 | Transmit clock, identical to `rx_clk` |
| searching | output | 1 | Loop is waiting for its first transition |
| locked | output | 1 | Loop is producing clocks |

## Verification
A data change reaches the loop three clock edges after it is applied. The first recovered rising edge is therefore due 34 edges after the launch. A correction shows up as the length of the cell in which the transition lands, measured between two consecutive rising edges of `rx_clk`. The bench drives and samples only on falling clock edges. It timestamps rising edges with its own cycle counter and places each transition a computed number of cycles after the rising edge that starts the cell. It then compares the interval, the high time and the first-edge latency against those counts.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

    localparam int CNT_W_DEF = 5;
    localparam int SYNC_DEF  = 2;
    localparam int HALF_PER_COUNT = 2;

    typedef enum logic [1:0] {
        LS_OFF    = 2'd0,
        LS_SEARCH = 2'd1,
        LS_TRACK  = 2'd2
    } loop_state_e;

    typedef enum logic {
        LM_TRACK = 1'b0,
        LM_COAST = 1'b1
    } loop_mode_e;

    typedef enum logic [1:0] {
        EC_NONE  = 2'd0,
        EC_EARLY = 2'd1,
        EC_DEAD  = 2'd2,
        EC_LATE  = 2'd3
    } edge_class_e;

    typedef struct packed {
        logic       search;
        logic       halt;
        logic       mode_wr;
        loop_mode_e mode;
    } loop_cmd_t;

    // Positions are half-counts; bound is the half-count where the nominal
    // boundary count begins. One half-count either side is tolerated.
    function automatic edge_class_e classify_edge(input int pos, input int bound,
                                                  input logic seen);
        edge_class_e c;
        if (!seen)               c = EC_NONE;
        else if (pos + 1 < bound) c = EC_EARLY;
        else if (pos <= bound)    c = EC_DEAD;
        else                      c = EC_LATE;
        return c;
    endfunction

endpackage

// File: rtl/cdr_edge_det.sv
module cdr_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic en,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    assign edge_o = en & (sync_q[STAGES-1] ^ last_q);
endmodule

// File: rtl/cdr_loop_ctrl.sv
module cdr_loop_ctrl
    import cdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  loop_cmd_t   cmd,
    input  logic        data_edge,
    output loop_state_e state_q,
    output loop_mode_e  mode_q
);
    loop_state_e state_d;
    loop_mode_e  mode_d;

    always_comb begin
        state_d = state_q;
        if (cmd.halt)
            state_d = LS_OFF;
        else if (cmd.search)
            state_d = LS_SEARCH;
        else if (state_q == LS_SEARCH && data_edge)
            state_d = LS_TRACK;
    end

    always_comb begin
        mode_d = mode_q;
        if (cmd.mode_wr && state_q == LS_OFF)
            mode_d = cmd.mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LS_OFF;
            mode_q  <= LM_TRACK;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end
endmodule

// File: rtl/cdr_phase_ctr.sv
module cdr_phase_ctr
    import cdr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  loop_state_e      state_i,
    input  loop_mode_e       mode_i,
    input  logic             data_edge,
    output logic [CNT_W:0]   ph_q,
    output logic             samp_clk
);
    localparam int PH_W     = CNT_W + 1;
    localparam int BOUNDARY = 1 << CNT_W;
    localparam logic [PH_W-1:0] PH_BOUND   = PH_W'(BOUNDARY);
    localparam logic [PH_W-1:0] PH_SYNC    = PH_W'(BOUNDARY + 1);
    localparam logic [PH_W-1:0] PH_LAST    = {PH_W{1'b1}};
    localparam logic [PH_W-1:0] STEP_NOM   = PH_W'(1);
    localparam logic [PH_W-1:0] STEP_SHORT = PH_W'(1 + HALF_PER_COUNT);
    localparam logic [PH_W-1:0] BACK_LONG  = PH_W'(HALF_PER_COUNT - 1);

    logic [PH_W-1:0] ph_d;
    logic            fixed_q, fixed_d;
    edge_class_e     cls;

    assign cls = classify_edge(32'(ph_q), BOUNDARY, data_edge);

    always_comb begin
        ph_d    = ph_q;
        fixed_d = fixed_q;
        unique case (state_i)
            LS_SEARCH: begin
                ph_d    = data_edge ? PH_SYNC : PH_BOUND;
                fixed_d = 1'b0;
            end
            LS_TRACK: begin
                ph_d = ph_q + STEP_NOM;
                if (ph_q == PH_LAST)
                    fixed_d = 1'b0;
                if (mode_i == LM_TRACK && !fixed_q) begin
                    if (cls == EC_EARLY) begin
                        ph_d    = ph_q + STEP_SHORT;
                        fixed_d = 1'b1;
                    end else if (cls == EC_LATE) begin
                        ph_d    = ph_q - BACK_LONG;
                        fixed_d = 1'b1;
                    end
                end
            end
            default: begin
                fixed_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_BOUND;
            fixed_q <= 1'b0;
        end else begin
            ph_q    <= ph_d;
            fixed_q <= fixed_d;
        end
    end

    assign samp_clk = (state_i == LS_TRACK) & ~ph_q[PH_W-1];
endmodule

// File: rtl/cdr_dpll.sv
module cdr_dpll
    import cdr_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_data,
    input  logic cmd_search,
    input  logic cmd_disable,
    input  logic cmd_mode_wr,
    input  logic mode_sel,
    output logic rx_clk,
    output logic tx_clk,
    output logic searching,
    output logic locked
);
    localparam int PH_W = CNT_W + 1;

    loop_cmd_t       cmd;
    loop_state_e     state_q;
    loop_mode_e      mode_q;
    logic            data_edge;
    logic [PH_W-1:0] ph_q;
    logic            samp_clk;

    assign cmd = '{search:  cmd_search,
                   halt:    cmd_disable,
                   mode_wr: cmd_mode_wr,
                   mode:    loop_mode_e'(mode_sel)};

    cdr_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .din    (rx_data),
        .en     (state_q != LS_OFF),
        .edge_o (data_edge)
    );

    cdr_loop_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .data_edge (data_edge),
        .state_q   (state_q),
        .mode_q    (mode_q)
    );

    cdr_phase_ctr #(.CNT_W(CNT_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .state_i   (state_q),
        .mode_i    (mode_q),
        .data_edge (data_edge),
        .ph_q      (ph_q),
        .samp_clk  (samp_clk)
    );

    assign rx_clk    = samp_clk;
    assign tx_clk    = samp_clk;
    assign searching = (state_q == LS_SEARCH);
    assign locked    = (state_q == LS_TRACK);
endmodule

// File: rtl/cdr_dpll_chk.sv
module cdr_dpll_chk
    import cdr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input logic            clk,
    input logic            rst,
    input logic            searching,
    input logic            locked,
    input logic            rx_clk,
    input logic            tx_clk,
    input loop_mode_e      mode_q,
    input loop_state_e     state_q,
    input logic [CNT_W:0]  ph_q
);
    localparam int PH_W     = CNT_W + 1;
    localparam int BOUNDARY = 1 << CNT_W;

    logic            prev_locked, prev_search, prev_off;
    loop_mode_e      prev_mode;
    logic [PH_W-1:0] ph_prev, ph_step;
    logic [1:0]      corr_cnt;

    assign ph_step = ph_q - ph_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_locked <= 1'b0;
            prev_search <= 1'b0;
            prev_off    <= 1'b1;
            prev_mode   <= LM_TRACK;
            ph_prev     <= PH_W'(BOUNDARY);
            corr_cnt    <= '0;
        end else begin
            prev_locked <= locked;
            prev_search <= searching;
            prev_off    <= (state_q == LS_OFF);
            prev_mode   <= mode_q;
            ph_prev     <= ph_q;
            if (!locked || !prev_locked || ph_q == '0)
                corr_cnt <= '0;
            else if (ph_step != PH_W'(1))
                corr_cnt <= corr_cnt + 2'd1;
        end
    end

    AST_IDLE_NO_CLK: assert property (@(posedge clk) disable iff (rst)
        !locked |-> (!rx_clk && !tx_clk)); // R2

    AST_SEARCH_HELD: assert property (@(posedge clk) disable iff (rst)
        (searching && prev_search) |-> (ph_q == PH_W'(BOUNDARY))); // R3

    AST_SYNC_POINT: assert property (@(posedge clk) disable iff (rst)
        (locked && !prev_locked) |-> (ph_q == PH_W'(BOUNDARY + 1))); // R4

    AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (locked && prev_locked) |->
        (ph_step == PH_W'(1) || ph_step == PH_W'(3) || ph_step == {PH_W{1'b1}})); // R7

    AST_ONE_FIX: assert property (@(posedge clk) disable iff (rst)
        corr_cnt <= 2'd1); // R9

    AST_COAST_STEADY: assert property (@(posedge clk) disable iff (rst)
        (locked && prev_locked && mode_q == LM_COAST) |-> (ph_step == PH_W'(1))); // R11

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode_q != prev_mode) |-> prev_off); // R11
endmodule

bind cdr_dpll cdr_dpll_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .searching (searching),
    .locked    (locked),
    .rx_clk    (rx_clk),
    .tx_clk    (tx_clk),
    .mode_q    (mode_q),
    .state_q   (state_q),
    .ph_q      (ph_q)
);

// File: tb/cdr_dpll_tb.sv
module cdr_dpll_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 9;
    localparam int VK [N_VEC] = '{0, 20, 28, 29, 30, 31, 45, 61, -1};
    localparam int VP [N_VEC] = '{62, 62, 62, 64, 64, 66, 66, 66, 64};

    logic clk = 1'b0;
    logic rst, rx_data, cmd_search, cmd_disable, cmd_mode_wr, mode_sel;
    logic rx_clk, tx_clk, searching, locked;
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cdr_dpll u_dut (
        .clk         (clk),
        .rst         (rst),
        .rx_data     (rx_data),
        .cmd_search  (cmd_search),
        .cmd_disable (cmd_disable),
        .cmd_mode_wr (cmd_mode_wr),
        .mode_sel    (mode_sel),
        .rx_clk      (rx_clk),
        .tx_clk      (tx_clk),
        .searching   (searching),
        .locked      (locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_search();
        @(negedge clk); cmd_search = 1'b1;
        @(negedge clk); cmd_search = 1'b0;
    endtask

    // Search, launch a sync transition, find the first rise, then measure the
    // next cell while placing transitions ka / kb cycles after that rise.
    task automatic run_cell(input int ka, input int kb, output int lat,
                            output int per, output int highs, output int txbad);
        int   launch, c1, c2, g;
        logic last;
        pulse_search();
        rx_data = ~rx_data;
        launch = cyc;
        last = rx_clk;
        c1 = -1; g = 0;
        while (c1 < 0 && g < 300) begin
            @(negedge clk); g++;
            if (rx_clk && !last) c1 = cyc;
            last = rx_clk;
        end
        lat = (c1 < 0) ? -1 : c1 - launch;
        highs = 0; txbad = 0; c2 = -1; g = 0;
        while (c2 < 0 && g < 300) begin
            if (ka >= 0 && cyc == c1 + ka) rx_data = ~rx_data;
            if (kb >= 0 && cyc == c1 + kb) rx_data = ~rx_data;
            if (rx_clk) highs++;
            if (tx_clk !== rx_clk) txbad++;
            last = rx_clk;
            @(negedge clk); g++;
            if (rx_clk && !last) c2 = cyc;
        end
        per = (c2 < 0) ? -1 : c2 - c1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        summary();
        $finish;
    end

    initial begin
        int lat, per, highs, txbad, seen;
        rst = 1'b1; rx_data = 1'b0; cmd_search = 1'b0; cmd_disable = 1'b0;
        cmd_mode_wr = 1'b0; mode_sel = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 rx_clk", int'(rx_clk), 0);
        chk("R1 tx_clk", int'(tx_clk), 0);
        chk("R1 searching", int'(searching), 0);
        chk("R1 locked", int'(locked), 0);

        // R2: edges ignored while stopped
        seen = 0;
        for (int i = 0; i < 120; i++) begin
            if (i % 17 == 0) rx_data = ~rx_data;
            @(negedge clk);
            if (rx_clk || locked) seen++;
        end
        chk("R2 no clock while stopped", seen, 0);

        // R3: search holds without edges
        pulse_search();
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (rx_clk || tx_clk || !searching) seen++;
        end
        chk("R3 search idle", seen, 0);

        // R1/R11: reset mode is tracking (a late edge is corrected)
        // vector table: R4 latency, R5/R6/R7/R8 cell length
        for (int v = 0; v < N_VEC; v++) begin
            run_cell(VK[v], -1, lat, per, highs, txbad);
            chk("R4 first rise latency", lat, 34);
            if (VP[v] == 62)      chk("R7 early edge cell length", per, VP[v]);
            else if (VP[v] == 66) chk("R8 late edge cell length", per, VP[v]);
            else if (VK[v] >= 0)  chk("R6 dead-band cell length", per, VP[v]);
            else                  chk("R5 free-run cell length", per, VP[v]);
            if (VP[v] == 64) chk("R5 high time", highs, 32);
            chk("R5 tx equals rx", txbad, 0);
        end

        // R9: two early edges in one cell give one correction
        run_cell(5, 15, lat, per, highs, txbad);
        chk("R9 single correction", per, 62);

        // R10: restart while locked
        @(negedge clk); cmd_search = 1'b1;
        @(negedge clk); cmd_search = 1'b0;
        chk("R10 searching after restart", int'(searching), 1);
        chk("R10 unlocked after restart", int'(locked), 0);
        chk("R10 clock low after restart", int'(rx_clk), 0);
        run_cell(-1, -1, lat, per, highs, txbad);
        chk("R10 relock latency", lat, 34);

        // R11: mode write while locked is ignored
        @(negedge clk); cmd_mode_wr = 1'b1; mode_sel = 1'b1;
        @(negedge clk); cmd_mode_wr = 1'b0; mode_sel = 1'b0;
        run_cell(45, -1, lat, per, highs, txbad);
        chk("R11 mode write ignored while locked", per, 66);

        // R12: stop wins over search
        @(negedge clk); cmd_search = 1'b1; cmd_disable = 1'b1;
        @(negedge clk); cmd_search = 1'b0; cmd_disable = 1'b0;
        chk("R12 searching after both", int'(searching), 0);
        chk("R12 locked after both", int'(locked), 0);
        chk("R12 clock after both", int'(rx_clk), 0);

        // R11: mode write while stopped selects coast
        @(negedge clk); cmd_mode_wr = 1'b1; mode_sel = 1'b1;
        @(negedge clk); cmd_mode_wr = 1'b0; mode_sel = 1'b0;
        run_cell(45, -1, lat, per, highs, txbad);
        chk("R11 coast latency", lat, 34);
        chk("R11 coast ignores late edge", per, 64);
        run_cell(10, -1, lat, per, highs, txbad);
        chk("R11 coast ignores early edge", per, 64);

        summary();
        $finish;
    end
endmodule